// File: doc/BRIEF.md
# AES Single-Round Execution Unit

This unit performs exactly one AES round step on a 128-bit block each time it is strobed. A 3-bit opcode selects the step: a middle or final encryption round, a middle or final decryption round in equivalent-inverse-cipher order, or an inverse column-mix transform. The inverse column-mix transform turns an encryption round key into the key that a middle decryption round expects. Software or a sequencer outside the unit chains the rounds and supplies each round key. Key expansion, cipher modes and round sequencing are the caller's job.

A block is stored column by column. Byte k of the AES state sits in bits [8k+7:8k], and bytes 4c to 4c+3 form column c, with row r at byte 4c+r. The result is registered, so it appears one clock after the input strobe and carries its own valid strobe. An opcode outside the defined set returns an all-zero result and raises a flag.

Top module: `aes_round_unit`

## Requirements
- R1: Opcode 0 (full encryption round) returns MixColumns(SubBytes(ShiftRows(state))) XOR key. MixColumns multiplies each column by the circulant {02,03,01,01} over GF(2^8) modulo 0x11B.
- R2: Opcode 1 (final encryption round) returns SubBytes(ShiftRows(state)) XOR key, with no column mix.
- R3: Opcode 2 (full decryption round) returns InvMixColumns(InvSubBytes(InvShiftRows(state))) XOR key. The key is added after the inverse mix, and InvMixColumns uses the circulant {0E,0B,0D,09}.
- R4: Opcode 3 (final decryption round) returns InvSubBytes(InvShiftRows(state)) XOR key.
- R5: Opcode 4 returns InvMixColumns of the state operand, and the key operand has no effect on it.
- R6: Opcodes 5, 6 and 7 return an all-zero result with out_illegal set to 1. A legal opcode returns with out_illegal set to 0.
- R7: Byte k of the state is in bits [8k+7:8k], and row r of column c is byte 4c+r. ShiftRows rotates row r left by r columns, so output column c takes row r from input column (c+r) mod 4. InvShiftRows takes it from column (c-r) mod 4.
- R8: When in_valid is 1 at a rising edge, out_valid is 1 and out_data/out_illegal show that operation's result after that edge. When in_valid is 0 at a rising edge, out_valid is 0 after that edge.
- R9: While in_valid is 0, out_data and out_illegal keep their last values.
- R10: The S-box is the GF(2^8) multiplicative inverse (0 maps to 0) followed by the AES affine transform with constant 0x63. The inverse S-box undoes it, so it holds for every one of the 256 byte values.
- R11: An asynchronous active-low reset clears out_valid, out_data and out_illegal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_op | input | 3 | Opcode: 0 enc, 1 enc final, 2 dec, 3 dec final, 4 key inverse-mix |
| in_state | input | 128 | State operand, byte 0 in bits [7:0] |
| in_key | input | 128 | Round-key operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | 128 | Registered result |
| out_illegal | output | 1 | Set when the captured opcode was undefined |

## Verification
The hardest case to reach from the ports is a single S-box or inverse S-box entry going wrong. One bad entry hides in random traffic and in the few bytes a test vector touches. The bench therefore feeds blocks with all sixteen bytes equal, for each of the 256 values. The column mix maps a uniform column to itself because the coefficients of both circulants XOR to 01, so every round opcode exposes one S-box entry directly. The bench compares these against a table it builds by brute-force inversion. Ordering faults in ShiftRows, key placement and the inverse mix show up by chaining ten rounds of the AES-128 known-answer vector and then decrypting it back with keys passed through opcode 4.

// File: rtl/aes_rnd_pkg.sv
package aes_rnd_pkg;

  localparam int BYTE_W  = 8;
  localparam int ROWS    = 4;
  localparam int COLS    = 4;
  localparam int COL_W   = BYTE_W * ROWS;
  localparam int BLK_W   = COL_W * COLS;
  localparam int NBYTES  = ROWS * COLS;
  localparam int OP_W    = 3;

  localparam logic [OP_W-1:0] OP_ENC     = 3'd0;
  localparam logic [OP_W-1:0] OP_ENCLAST = 3'd1;
  localparam logic [OP_W-1:0] OP_DEC     = 3'd2;
  localparam logic [OP_W-1:0] OP_DECLAST = 3'd3;
  localparam logic [OP_W-1:0] OP_IMC     = 3'd4;

  localparam logic [BYTE_W-1:0] POLY_LOW   = 8'h1b;
  localparam logic [BYTE_W-1:0] AFFINE_C   = 8'h63;
  localparam logic [BYTE_W-1:0] INV_AFF_C  = 8'h05;
  localparam logic [BYTE_W-1:0] INV_EXP    = 8'hfe;

  // multiply by x modulo x^8+x^4+x^3+x+1
  function automatic logic [BYTE_W-1:0] gf_xtime(input logic [BYTE_W-1:0] a);
    return {a[BYTE_W-2:0], 1'b0} ^ (a[BYTE_W-1] ? POLY_LOW : 8'h00);
  endfunction

  function automatic logic [BYTE_W-1:0] gf_mul(input logic [BYTE_W-1:0] a,
                                               input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] acc;
    logic [BYTE_W-1:0] sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_xtime(sh);
    end
    return acc;
  endfunction

  // a^254 gives the multiplicative inverse, and 0 for 0
  function automatic logic [BYTE_W-1:0] gf_inv(input logic [BYTE_W-1:0] a);
    logic [BYTE_W-1:0] r;
    logic [BYTE_W-1:0] sq;
    r  = 8'h01;
    sq = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (INV_EXP[i]) r = gf_mul(r, sq);
      sq = gf_mul(sq, sq);
    end
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] rotl8(input logic [BYTE_W-1:0] b, input int n);
    return (b << n) | (b >> (BYTE_W - n));
  endfunction

  function automatic logic [BYTE_W-1:0] sbox_fwd(input logic [BYTE_W-1:0] a);
    logic [BYTE_W-1:0] b;
    b = gf_inv(a);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ AFFINE_C;
  endfunction

  function automatic logic [BYTE_W-1:0] sbox_inv(input logic [BYTE_W-1:0] a);
    logic [BYTE_W-1:0] b;
    b = rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ INV_AFF_C;
    return gf_inv(b);
  endfunction

  // one column times a circulant whose first row is c0..c3
  function automatic logic [COL_W-1:0] mix_col(input logic [COL_W-1:0] col,
                                               input logic [COL_W-1:0] coef);
    logic [COL_W-1:0] o;
    logic [BYTE_W-1:0] acc;
    for (int r = 0; r < ROWS; r++) begin
      acc = '0;
      for (int k = 0; k < ROWS; k++)
        acc = acc ^ gf_mul(coef[((k - r + ROWS) % ROWS)*BYTE_W +: BYTE_W],
                           col[k*BYTE_W +: BYTE_W]);
      o[r*BYTE_W +: BYTE_W] = acc;
    end
    return o;
  endfunction

  // coefficient rows packed with the first coefficient in the low byte
  localparam logic [COL_W-1:0] MIX_FWD_COEF = 32'h01010302;
  localparam logic [COL_W-1:0] MIX_INV_COEF = 32'h090d0b0e;

endpackage

// File: rtl/aes_rnd_shift.sv
module aes_rnd_shift
  import aes_rnd_pkg::*;
#(
  parameter bit INV = 1'b0
) (
  input  logic [BLK_W-1:0] din,
  output logic [BLK_W-1:0] dout
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      localparam int SRC_C = INV ? ((c - r + COLS) % COLS) : ((c + r) % COLS);
      assign dout[(c*ROWS + r)*BYTE_W +: BYTE_W] = din[(SRC_C*ROWS + r)*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/aes_rnd_subst.sv
module aes_rnd_subst
  import aes_rnd_pkg::*;
#(
  parameter bit INV = 1'b0
) (
  input  logic [BLK_W-1:0] din,
  output logic [BLK_W-1:0] dout
);
  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    if (INV) begin : g_inv
      assign dout[k*BYTE_W +: BYTE_W] = sbox_inv(din[k*BYTE_W +: BYTE_W]);
    end else begin : g_fwd
      assign dout[k*BYTE_W +: BYTE_W] = sbox_fwd(din[k*BYTE_W +: BYTE_W]);
    end
  end
endmodule

// File: rtl/aes_rnd_mixer.sv
module aes_rnd_mixer
  import aes_rnd_pkg::*;
#(
  parameter bit INV = 1'b0
) (
  input  logic [BLK_W-1:0] din,
  output logic [BLK_W-1:0] dout
);
  localparam logic [COL_W-1:0] COEF = INV ? MIX_INV_COEF : MIX_FWD_COEF;
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign dout[c*COL_W +: COL_W] = mix_col(din[c*COL_W +: COL_W], COEF);
  end
endmodule

// File: rtl/aes_round_unit.sv
module aes_round_unit
  import aes_rnd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  in_op,
  input  logic [BLK_W-1:0] in_state,
  input  logic [BLK_W-1:0] in_key,
  output logic             out_valid,
  output logic [BLK_W-1:0] out_data,
  output logic             out_illegal
);
  logic [BLK_W-1:0] sh_fwd, sb_fwd, mx_fwd;
  logic [BLK_W-1:0] sh_inv, sb_inv, mx_inv_src, mx_inv;
  logic [BLK_W-1:0] pre_key, nxt_res;
  logic             op_legal;
  logic             add_key;

  aes_rnd_shift #(.INV(1'b0)) u_sh_fwd (.din(in_state), .dout(sh_fwd));
  aes_rnd_subst #(.INV(1'b0)) u_sb_fwd (.din(sh_fwd),   .dout(sb_fwd));
  aes_rnd_mixer #(.INV(1'b0)) u_mx_fwd (.din(sb_fwd),   .dout(mx_fwd));

  aes_rnd_shift #(.INV(1'b1)) u_sh_inv (.din(in_state),   .dout(sh_inv));
  aes_rnd_subst #(.INV(1'b1)) u_sb_inv (.din(sh_inv),     .dout(sb_inv));
  aes_rnd_mixer #(.INV(1'b1)) u_mx_inv (.din(mx_inv_src), .dout(mx_inv));

  // the key-conversion op reuses the inverse mixer on the raw operand
  assign mx_inv_src = (in_op == OP_IMC) ? in_state : sb_inv;

  always_comb begin
    op_legal = 1'b1;
    add_key  = 1'b1;
    pre_key  = '0;
    case (in_op)
      OP_ENC:     pre_key = mx_fwd;
      OP_ENCLAST: pre_key = sb_fwd;
      OP_DEC:     pre_key = mx_inv;
      OP_DECLAST: pre_key = sb_inv;
      OP_IMC: begin
        pre_key = mx_inv;
        add_key = 1'b0;
      end
      default: begin
        op_legal = 1'b0;
        add_key  = 1'b0;
      end
    endcase
  end

  assign nxt_res = add_key ? (pre_key ^ in_key) : pre_key;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data    <= nxt_res;
        out_illegal <= ~op_legal;
      end
    end
  end
endmodule

// File: rtl/aes_rnd_chk.sv
module aes_rnd_chk
  import aes_rnd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [OP_W-1:0]  in_op,
  input logic [BLK_W-1:0] in_state,
  input logic [BLK_W-1:0] in_key,
  input logic             out_valid,
  input logic [BLK_W-1:0] out_data,
  input logic             out_illegal,
  input logic             op_legal
);
  // R8: strobe latency
  p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R9: hold while idle
  p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_illegal)));

  // R6: undefined opcode gives zero and the flag
  p_illegal_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op_legal) |=> (out_illegal && out_data == '0));
  p_legal_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op <= OP_IMC) |=> !out_illegal);

  // R2: an all-zero state through the final round gives S(0)=63 in every byte
  p_enclast_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_ENCLAST && in_state == '0)
      |=> (out_data == ($past(in_key) ^ {NBYTES{AFFINE_C}})));

  // R5: inverse mix of zero is zero whatever the key
  p_imc_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == OP_IMC && in_state == '0) |=> (out_data == '0));
endmodule

bind aes_round_unit aes_rnd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
  .in_state(in_state), .in_key(in_key), .out_valid(out_valid),
  .out_data(out_data), .out_illegal(out_illegal), .op_legal(op_legal)
);

// File: tb/aes_round_unit_bench.sv
`timescale 1ns/1ps
module aes_round_unit_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [2:0]   in_op = '0;
  logic [127:0] in_state = '0;
  logic [127:0] in_key = '0;
  logic         out_valid;
  logic [127:0] out_data;
  logic         out_illegal;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0]   sb_t [256];
  logic [127:0] rk [11];

  always #2.5 clk = ~clk;

  aes_round_unit u_aes_round_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_state(in_state), .in_key(in_key), .out_valid(out_valid),
    .out_data(out_data), .out_illegal(out_illegal)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // peasant multiply, written apart from the design's form
  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    logic [7:0] x = a;
    logic [7:0] y = b;
    while (y != 0) begin
      if (y[0]) p ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return p;
  endfunction

  function automatic logic [127:0] rev(input logic [127:0] v);
    logic [127:0] o;
    for (int i = 0; i < 16; i++) o[8*i +: 8] = v[127-8*i -: 8];
    return o;
  endfunction

  function automatic logic [31:0] subw(input logic [31:0] w);
    return {sb_t[w[31:24]], sb_t[w[23:16]], sb_t[w[15:8]], sb_t[w[7:0]]};
  endfunction

  task automatic build_tables();
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b = 0;
      logic [7:0] c = 8'h63;
      logic [7:0] o;
      for (int y = 1; y < 256; y++)
        if (bmul(v[7:0], y[7:0]) == 8'h01) b = y[7:0];
      for (int i = 0; i < 8; i++)
        o[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8] ^ c[i];
      sb_t[v] = o;
    end
  endtask

  task automatic expand_key(input logic [127:0] key_be);
    logic [31:0] w [44];
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key_be[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t = w[i-1];
      if (i % 4 == 0) begin
        t = subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = bmul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rk[r] = rev({w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]});
  endtask

  // drive at a falling edge, read the registered result one falling edge later
  task automatic run_op(input logic [2:0] op, input logic [127:0] st,
                        input logic [127:0] key, output logic [127:0] res);
    in_valid = 1'b1; in_op = op; in_state = st; in_key = key;
    @(negedge clk);
    res = out_data;
    in_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      summary();
    end
  end

  initial begin
    logic [127:0] res, st, pt, ct, k_dec;
    build_tables();
    repeat (3) @(negedge clk);
    // R11: reset values
    chk("R11 valid", {127'd0, out_valid}, 128'd0);
    chk("R11 data", out_data, 128'd0);
    chk("R11 illegal", {127'd0, out_illegal}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8: strobe timing
    in_valid = 1'b1; in_op = 3'd1; in_state = '0; in_key = '0;
    @(negedge clk);
    chk("R8 valid high", {127'd0, out_valid}, 128'd1);
    chk("R2 zero state", out_data, {16{8'h63}});
    in_valid = 1'b0; in_state = {16{8'h5a}}; in_key = {16{8'hff}};
    @(negedge clk);
    chk("R8 valid low", {127'd0, out_valid}, 128'd0);
    chk("R9 hold", out_data, {16{8'h63}});
    @(negedge clk);
    chk("R9 hold again", out_data, {16{8'h63}});

    // R10: uniform blocks expose each S-box entry through every round op
    for (int v = 0; v < 256; v++) begin
      run_op(3'd1, {16{v[7:0]}}, '0, res);
      chk("R10 R2 sbox", res, {16{sb_t[v]}});
      run_op(3'd0, {16{v[7:0]}}, {16{8'h0f}}, res);
      chk("R10 R1 sbox", res, {16{sb_t[v] ^ 8'h0f}});
      run_op(3'd3, {16{sb_t[v]}}, '0, res);
      chk("R10 R4 inverse sbox", res, {16{v[7:0]}});
      run_op(3'd2, {16{sb_t[v]}}, {16{8'hf0}}, res);
      chk("R10 R3 inverse sbox", res, {16{v[7:0] ^ 8'hf0}});
    end

    // R5: known column db135345 <-> 8e4da1bc, key ignored
    run_op(3'd4, {4{32'hbca14d8e}}, {16{8'ha5}}, res);
    chk("R5 imc column", res, {4{32'h455313db}});
    run_op(3'd4, {4{32'hbca14d8e}}, '0, res);
    chk("R5 imc key ignored", res, {4{32'h455313db}});

    // R6: undefined opcodes
    for (int op = 5; op < 8; op++) begin
      run_op(op[2:0], {16{8'h3c}}, {16{8'hc3}}, res);
      chk("R6 zero result", res, '0);
      chk("R6 flag set", {127'd0, out_illegal}, 128'd1);
    end
    run_op(3'd4, '0, '0, res);
    chk("R6 flag clear", {127'd0, out_illegal}, 128'd0);

    // R1 R2 R7: ten chained rounds of the AES-128 known answer
    expand_key(128'h000102030405060708090a0b0c0d0e0f);
    pt = rev(128'h00112233445566778899aabbccddeeff);
    st = pt ^ rk[0];
    for (int r = 1; r < 10; r++) run_op(3'd0, st, rk[r], st);
    run_op(3'd1, st, rk[10], ct);
    chk("R1 R2 R7 ciphertext", ct, rev(128'h69c4e0d86a7b0430d8cdb78070b4c55a));

    // R3 R4 R5: equivalent inverse cipher with converted keys
    st = ct ^ rk[10];
    for (int r = 9; r >= 1; r--) begin
      run_op(3'd4, rk[r], '0, k_dec);
      run_op(3'd2, st, k_dec, st);
    end
    run_op(3'd3, st, rk[0], res);
    chk("R3 R4 R5 plaintext restored", res, pt);

    done = 1'b1;
    summary();
  end
endmodule